// File: doc/BRIEF.md
# Random Word Output Buffer Controller

This block sits on the output side of an entropy source. The conditioning stage hands it 128-bit blocks. The block keeps one block waiting in a staging register and a second block spread across a four-entry FIFO of 32-bit words. Software takes the words one at a time through a registered read port. The FIFO is reloaded only with a whole block, and only after all four of its words have been drained. Each reload issues a one-cycle request for a new conditioning round.

A data-ready output shows that at least one word can be read. A read while the FIFO is empty returns zero. The interrupt line combines three sources:
- a one-cycle pulse when data-ready rises;
- the seed-error status level;
- the clock-error status level.

The interrupt is qualified by the interrupt enable and by the generator enable. Buffered words stay readable while the generator is disabled. A seed error flushes everything held, and a conditioning soft reset clears everything.

Sequencing is handled by a three-state machine:
- `ST_WAIT`: the FIFO is empty.
- `ST_SERVE`: the FIFO holds words.
- `ST_HALT`: a seed error is active.

Transitions:
- `ST_WAIT` to `ST_SERVE` when the staging register is full (load).
- `ST_SERVE` to `ST_SERVE` when the last word is read and a block is staged (direct reload).
- `ST_SERVE` to `ST_WAIT` when the last word is read and nothing is staged.
- Any state to `ST_HALT` while the seed error is high.
- `ST_HALT` to `ST_WAIT` when the seed error drops.
- Any state to `ST_WAIT` on soft reset.

Top module: `rwb_ctrl`

## Requirements
- R1: The FIFO holds four 32-bit words. `data_rdy` stays 1 while any word remains, and exactly four reads empty a freshly loaded FIFO.
- R2: Word k of a block is bits [32k+31:32k], and words are delivered from k=0 upward. Each read strobe sampled at a rising edge updates `rd_data` at that edge.
- R3: A block moves from staging to the FIFO only when the FIFO is empty, and always as all four words. Each move makes `round_req` high for exactly the one cycle in which the new words first become readable.
- R4: A read while `data_rdy` is 0 returns 0x00000000.
- R5: When `gen_en` and `irq_en` are 1, `irq` is high for exactly one cycle after `data_rdy` goes from 0 to 1. It then clears with no software action.
- R6: `irq` is high while `seed_err` or `clk_err` is 1 and both enables are 1. `irq` is never high while `gen_en` is 0.
- R7: Words already buffered can be read in full while `gen_en` is 0.
- R8: A block that arrives while the staging register is full, and is not moved out in that cycle, is dropped. The staged block is kept unchanged, and `stage_ovf` becomes 1 and stays 1 until soft reset.
- R9: While `seed_err` is 1, the FIFO and staging register are emptied and incoming blocks are ignored. No word from before the fault is delivered afterwards.
- R10: `cond_rst` empties the FIFO and staging register and clears `data_rdy`, `stage_ovf` and `rd_data`.
- R11: After `rst_n` is released, `data_rdy`, `rd_data`, `round_req`, `irq` and `stage_ovf` are all 0.
- R12: If the last word is read while a block is staged, the FIFO reloads at that same edge. `data_rdy` stays 1 without a gap, and no new interrupt pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_rst | input | 1 | Conditioning soft reset, synchronous |
| gen_en | input | 1 | Generator enable, gates the interrupt |
| irq_en | input | 1 | Interrupt enable |
| blk_valid | input | 1 | Conditioned block strobe |
| blk_data | input | 128 | Conditioned block |
| rd_req | input | 1 | Word read strobe |
| seed_err | input | 1 | Seed-error interrupt status |
| clk_err | input | 1 | Clock-error interrupt status |
| rd_data | output | 32 | Last word read, zero if read while empty |
| data_rdy | output | 1 | At least one word readable |
| round_req | output | 1 | New conditioning round request pulse |
| irq | output | 1 | Combined interrupt request |
| stage_ovf | output | 1 | Sticky dropped-block debug flag |

## Verification
Blocks are built so that every word carries a distinct value. A swapped word order, a repeated word or a stale block therefore shows up as a wrong value on a specific read.

Three block-arrival patterns are applied:
- a single block into an empty buffer, which shows the load path and the interrupt edge;
- three back-to-back blocks, which tell a kept staged block apart from an overwritten one and show the gapless direct reload;
- blocks arriving during a seed fault or around a soft reset, which tell a real flush apart from words left behind.

The error inputs are toggled against each enable to separate the level sources from the edge source.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_SERVE = 2'd1,
        ST_HALT  = 2'd2
    } rwb_state_e;
endpackage

// File: rtl/rwb_stage.sv
module rwb_stage #(
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             flush,
    input  logic             blk_valid,
    input  logic [BLK_W-1:0] blk_data,
    input  logic             take,
    output logic [BLK_W-1:0] stage_data,
    output logic             stage_full,
    output logic             ovf
);
    logic accept;
    logic drop;

    assign accept = blk_valid && !soft_rst && !flush && (!stage_full || take);
    assign drop   = blk_valid && !soft_rst && !flush && stage_full && !take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_data <= '0;
            stage_full <= 1'b0;
            ovf        <= 1'b0;
        end else if (soft_rst) begin
            stage_data <= '0;
            stage_full <= 1'b0;
            ovf        <= 1'b0;
        end else if (flush) begin
            stage_data <= '0;
            stage_full <= 1'b0;
        end else begin
            if (accept) begin
                stage_data <= blk_data;
                stage_full <= 1'b1;
            end else if (take) begin
                stage_full <= 1'b0;
            end
            if (drop) begin
                ovf <= 1'b1;
            end
        end
    end

    // R8
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_valid && stage_full && !take && !flush && !soft_rst |=> ovf);

    // R8
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_full && !take && !flush && !soft_rst |=> stage_full && $stable(stage_data));
endmodule

// File: rtl/rwb_fifo.sv
module rwb_fifo #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    soft_rst,
    input  logic                    flush,
    input  logic                    load,
    input  logic [WORD_W*WORDS-1:0] load_data,
    input  logic                    rd_req,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    data_rdy,
    output logic                    last_rd
);
    localparam int BLK_W = WORD_W * WORDS;
    localparam int CNT_W = $clog2(WORDS + 1);
    localparam int PTR_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [BLK_W-1:0]  buf_q;
    logic [CNT_W-1:0]  cnt;
    logic [PTR_W-1:0]  ptr;
    logic [WORD_W-1:0] slot [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_slot
        assign slot[g] = buf_q[g*WORD_W +: WORD_W];
    end

    assign data_rdy = (cnt != '0);
    assign last_rd  = rd_req && (cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= '0;
            cnt     <= '0;
            ptr     <= '0;
            rd_data <= '0;
        end else if (soft_rst || flush) begin
            buf_q   <= '0;
            cnt     <= '0;
            ptr     <= '0;
            rd_data <= '0;
        end else begin
            if (rd_req) begin
                rd_data <= data_rdy ? slot[ptr] : '0;
                if (data_rdy) begin
                    cnt <= cnt - CNT_W'(1);
                    ptr <= (ptr == PTR_W'(WORDS - 1)) ? '0 : ptr + PTR_W'(1);
                end
            end
            if (load) begin
                buf_q <= load_data;
                cnt   <= CNT_W'(WORDS);
                ptr   <= '0;
            end
        end
    end

    // R4
    empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !data_rdy && !soft_rst && !flush |=> rd_data == '0);

    // R1
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && data_rdy && !load && !soft_rst && !flush |=> cnt == $past(cnt) - CNT_W'(1));
endmodule

// File: rtl/rwb_seq.sv
module rwb_seq
    import rwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic seed_err,
    input  logic stage_full,
    input  logic last_rd,
    output logic load,
    output logic flush,
    output logic round_req
);
    rwb_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        flush    = 1'b0;
        if (soft_rst) begin
            state_nx = ST_WAIT;
        end else if (seed_err) begin
            state_nx = ST_HALT;
            flush    = 1'b1;
        end else begin
            unique case (state)
                ST_WAIT: begin
                    if (stage_full) begin
                        load     = 1'b1;
                        state_nx = ST_SERVE;
                    end
                end
                ST_SERVE: begin
                    if (last_rd) begin
                        if (stage_full) begin
                            load     = 1'b1;
                            state_nx = ST_SERVE;
                        end else begin
                            state_nx = ST_WAIT;
                        end
                    end
                end
                ST_HALT: begin
                    state_nx = ST_WAIT;
                end
                default: begin
                    state_nx = ST_WAIT;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            round_req <= 1'b0;
        end else begin
            round_req <= load;
        end
    end

    // R9
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_err && !soft_rst |=> state == ST_HALT);
endmodule

// File: rtl/rwb_irq.sv
module rwb_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic data_rdy,
    input  logic gen_en,
    input  logic irq_en,
    input  logic seed_err,
    input  logic clk_err,
    output logic irq
);
    logic drdy_q;
    logic drdy_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_q <= 1'b0;
        end else if (soft_rst) begin
            drdy_q <= 1'b0;
        end else begin
            drdy_q <= data_rdy;
        end
    end

    assign drdy_rise = data_rdy && !drdy_q;
    assign irq       = gen_en && irq_en && (drdy_rise || seed_err || clk_err);

    // R5
    irq_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_rdy && $past(data_rdy) && !seed_err && !clk_err |-> !irq);
endmodule

// File: rtl/rwb_ctrl.sv
module rwb_ctrl #(
    parameter int WORD_W = 32,
    parameter int WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cond_rst,
    input  logic                    gen_en,
    input  logic                    irq_en,
    input  logic                    blk_valid,
    input  logic [WORD_W*WORDS-1:0] blk_data,
    input  logic                    rd_req,
    input  logic                    seed_err,
    input  logic                    clk_err,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    data_rdy,
    output logic                    round_req,
    output logic                    irq,
    output logic                    stage_ovf
);
    localparam int BLK_W = WORD_W * WORDS;

    logic [BLK_W-1:0] stage_data;
    logic             stage_full;
    logic             load;
    logic             flush;
    logic             last_rd;

    rwb_stage #(.BLK_W(BLK_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (cond_rst),
        .flush      (flush),
        .blk_valid  (blk_valid),
        .blk_data   (blk_data),
        .take       (load),
        .stage_data (stage_data),
        .stage_full (stage_full),
        .ovf        (stage_ovf)
    );

    rwb_fifo #(.WORD_W(WORD_W), .WORDS(WORDS)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (cond_rst),
        .flush     (flush),
        .load      (load),
        .load_data (stage_data),
        .rd_req    (rd_req),
        .rd_data   (rd_data),
        .data_rdy  (data_rdy),
        .last_rd   (last_rd)
    );

    rwb_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (cond_rst),
        .seed_err   (seed_err),
        .stage_full (stage_full),
        .last_rd    (last_rd),
        .load       (load),
        .flush      (flush),
        .round_req  (round_req)
    );

    rwb_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (cond_rst),
        .data_rdy (data_rdy),
        .gen_en   (gen_en),
        .irq_en   (irq_en),
        .seed_err (seed_err),
        .clk_err  (clk_err),
        .irq      (irq)
    );

    // R3
    round_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_req |-> data_rdy);

    // R9
    seed_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_err && !cond_rst |=> !data_rdy);
endmodule

// File: tb/sim_rwb_ctrl.sv
`timescale 1ns/1ps
module sim_rwb_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cond_rst = 1'b0;
    logic         gen_en = 1'b0;
    logic         irq_en = 1'b0;
    logic         blk_valid = 1'b0;
    logic [127:0] blk_data = '0;
    logic         rd_req = 1'b0;
    logic         seed_err = 1'b0;
    logic         clk_err = 1'b0;
    logic [31:0]  rd_data;
    logic         data_rdy;
    logic         round_req;
    logic         irq;
    logic         stage_ovf;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    rwb_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cond_rst(cond_rst), .gen_en(gen_en),
        .irq_en(irq_en), .blk_valid(blk_valid), .blk_data(blk_data),
        .rd_req(rd_req), .seed_err(seed_err), .clk_err(clk_err),
        .rd_data(rd_data), .data_rdy(data_rdy), .round_req(round_req),
        .irq(irq), .stage_ovf(stage_ovf)
    );

    function automatic logic [127:0] mk_blk(input logic [31:0] base);
        return {base + 32'd3, base + 32'd2, base + 32'd1, base};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push_blk(input logic [127:0] d);
        blk_valid = 1'b1;
        blk_data  = d;
        step();
        blk_valid = 1'b0;
    endtask

    task automatic read_word(output logic [31:0] w);
        rd_req = 1'b1;
        step();
        rd_req = 1'b0;
        w = rd_data;
    endtask

    task automatic t_reset();
        chk(data_rdy == 1'b0, "R11 data_rdy", 32'(data_rdy), 32'd0);
        chk(rd_data == 32'd0, "R11 rd_data", rd_data, 32'd0);
        chk(round_req == 1'b0, "R11 round_req", 32'(round_req), 32'd0);
        chk(irq == 1'b0, "R11 irq", 32'(irq), 32'd0);
        chk(stage_ovf == 1'b0, "R11 stage_ovf", 32'(stage_ovf), 32'd0);
    endtask

    task automatic t_basic();
        logic [31:0] w;
        gen_en = 1'b1;
        irq_en = 1'b1;
        push_blk(mk_blk(32'hA000_0010));
        chk(data_rdy == 1'b0, "R3 not yet loaded", 32'(data_rdy), 32'd0);
        step();
        chk(data_rdy == 1'b1, "R1 data_rdy after load", 32'(data_rdy), 32'd1);
        chk(round_req == 1'b1, "R3 round_req pulse", 32'(round_req), 32'd1);
        chk(irq == 1'b1, "R5 irq edge", 32'(irq), 32'd1);
        for (int k = 0; k < 4; k++) begin
            read_word(w);
            chk(w == 32'hA000_0010 + 32'(k), "R2 word order", w, 32'hA000_0010 + 32'(k));
            if (k == 0) begin
                chk(round_req == 1'b0, "R3 round_req one cycle", 32'(round_req), 32'd0);
                chk(irq == 1'b0, "R5 irq self clear", 32'(irq), 32'd0);
            end
            if (k < 3) chk(data_rdy == 1'b1, "R1 still ready", 32'(data_rdy), 32'd1);
        end
        chk(data_rdy == 1'b0, "R1 empty after four", 32'(data_rdy), 32'd0);
        read_word(w);
        chk(w == 32'd0, "R4 empty read zero", w, 32'd0);
    endtask

    task automatic t_overflow_reload();
        logic [31:0] w;
        push_blk(mk_blk(32'hB000_0000));
        step();
        push_blk(mk_blk(32'hC000_0000));
        push_blk(mk_blk(32'hD000_0000));
        chk(stage_ovf == 1'b1, "R8 ovf set", 32'(stage_ovf), 32'd1);
        for (int k = 0; k < 4; k++) begin
            read_word(w);
            chk(w == 32'hB000_0000 + 32'(k), "R2 first block", w, 32'hB000_0000 + 32'(k));
        end
        chk(data_rdy == 1'b1, "R12 no gap", 32'(data_rdy), 32'd1);
        chk(irq == 1'b0, "R12 no new irq", 32'(irq), 32'd0);
        chk(round_req == 1'b1, "R3 reload round_req", 32'(round_req), 32'd1);
        for (int k = 0; k < 4; k++) begin
            read_word(w);
            chk(w == 32'hC000_0000 + 32'(k), "R8 staged block kept", w, 32'hC000_0000 + 32'(k));
        end
        chk(data_rdy == 1'b0, "R3 no partial refill", 32'(data_rdy), 32'd0);
        chk(stage_ovf == 1'b1, "R8 ovf sticky", 32'(stage_ovf), 32'd1);
    endtask

    task automatic t_disabled();
        logic [31:0] w;
        gen_en = 1'b0;
        push_blk(mk_blk(32'hE000_0000));
        step();
        chk(data_rdy == 1'b1, "R7 loaded while off", 32'(data_rdy), 32'd1);
        chk(irq == 1'b0, "R6 no irq while off", 32'(irq), 32'd0);
        for (int k = 0; k < 4; k++) begin
            read_word(w);
            chk(w == 32'hE000_0000 + 32'(k), "R7 read while off", w, 32'hE000_0000 + 32'(k));
        end
        gen_en = 1'b1;
    endtask

    task automatic t_errors();
        clk_err = 1'b1;
        #1;
        chk(irq == 1'b1, "R6 clk_err irq", 32'(irq), 32'd1);
        irq_en = 1'b0;
        #1;
        chk(irq == 1'b0, "R6 irq_en gate", 32'(irq), 32'd0);
        irq_en = 1'b1;
        gen_en = 1'b0;
        #1;
        chk(irq == 1'b0, "R6 gen_en gate", 32'(irq), 32'd0);
        gen_en = 1'b1;
        clk_err = 1'b0;
        #1;
        chk(irq == 1'b0, "R6 clk_err released", 32'(irq), 32'd0);
        step();
    endtask

    task automatic t_seed();
        logic [31:0] w;
        push_blk(mk_blk(32'h1100_0000));
        step();
        read_word(w);
        push_blk(mk_blk(32'h2200_0000));
        seed_err = 1'b1;
        step();
        chk(data_rdy == 1'b0, "R9 flushed", 32'(data_rdy), 32'd0);
        chk(irq == 1'b1, "R6 seed_err irq", 32'(irq), 32'd1);
        push_blk(mk_blk(32'h3300_0000));
        seed_err = 1'b0;
        step();
        step();
        step();
        chk(data_rdy == 1'b0, "R9 stage flushed and block ignored", 32'(data_rdy), 32'd0);
        read_word(w);
        chk(w == 32'd0, "R9 no stale word", w, 32'd0);
    endtask

    task automatic t_softrst();
        logic [31:0] w;
        push_blk(mk_blk(32'h4400_0000));
        step();
        push_blk(mk_blk(32'h5500_0000));
        push_blk(mk_blk(32'h6600_0000));
        read_word(w);
        cond_rst = 1'b1;
        step();
        cond_rst = 1'b0;
        chk(data_rdy == 1'b0, "R10 data_rdy cleared", 32'(data_rdy), 32'd0);
        chk(stage_ovf == 1'b0, "R10 ovf cleared", 32'(stage_ovf), 32'd0);
        chk(rd_data == 32'd0, "R10 rd_data cleared", rd_data, 32'd0);
        step();
        step();
        chk(data_rdy == 1'b0, "R10 stage cleared", 32'(data_rdy), 32'd0);
        push_blk(mk_blk(32'h7700_0000));
        step();
        read_word(w);
        chk(w == 32'h7700_0000, "R10 fresh block after reset", w, 32'h7700_0000);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            finish_run();
        end
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_overflow_reload();
        t_disabled();
        t_errors();
        t_seed();
        t_softrst();
        finish_run();
    end
endmodule